// File: doc/BRIEF.md
# Register-List Stack Transfer Sequencer

This block moves a chosen group of registers between a register file and a stack held in a 16-bit-wide memory. A caller pulses start with a direction (push or pop), an 8-bit selection mask, a bank select that chooses registers 0 to 7 or 8 to 15, a width select for word or byte registers, and the current stack pointer. The sequencer then handles one selected register per clock. It drives the register-file read port on a push or the write port on a pop, drives the stack memory port, and returns the final stack pointer alongside a one-cycle done pulse so the caller can commit it.

Every register takes a full two-byte stack slot, in byte mode as well. Push works from the highest selected register down to the lowest and pre-decrements the pointer. Pop works from the lowest up to the highest and post-increments it. A sequence of pushes followed by a pop with the same mask therefore puts every value back where it came from. The register-file read data and the memory read data are combinational in the access cycle. The block has no stall input and no back-pressure: once a transfer starts, each port access completes in its own cycle.

Top module: `regstk_seq`

## Requirements
- R1: After reset, busy_o, done_o, rf_rd_en_o, rf_wr_en_o and mem_en_o are all low.
- R2: Mask bit i selects register i when upper_i is 0 and register 8+i when upper_i is 1. rf_addr_o carries {upper, i}.
- R3: Push (pop_i=0) visits the set mask bits from bit 7 down to bit 0. For each one it subtracts 2 from the stack pointer, then writes the register's value to memory at the new pointer.
- R4: Pop (pop_i=1) visits the set mask bits from bit 0 up to bit 7. For each one it reads memory at the current pointer, writes that value into the register, then adds 2 to the pointer.
- R5: In byte mode (byte_i=1), rf_byte_o is high and each register still moves the pointer by 2. Push stores the register's byte zero-extended into the 16-bit slot. Pop writes the low byte of the slot, zero-extended on rf_wr_data_o.
- R6: busy_o is high for exactly as many cycles as the mask has set bits, with one register access per cycle. done_o pulses for one cycle immediately after the last access, with busy_o low.
- R7: A start with an all-zero mask raises done_o in the next cycle, never raises busy_o, and returns sp_o equal to sp_i.
- R8: While done_o is high, sp_o equals sp_i minus 2 times the number of selected registers for a push, or plus that amount for a pop.
- R9: A start while busy_o is high is ignored. The running transfer completes unchanged, and no extra transfer or done pulse follows it.
- R10: The stack pointer wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (accepted only while idle) |
| pop_i | input | 1 | 1 = pop from stack, 0 = push to stack |
| mask_i | input | 8 | Register selection mask |
| upper_i | input | 1 | 1 = registers 8..15, 0 = registers 0..7 |
| byte_i | input | 1 | 1 = byte registers, 0 = word registers |
| sp_i | input | 16 | Stack pointer at start |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | 16 | Final stack pointer, valid with done_o |
| rf_rd_en_o | output | 1 | Register-file read strobe (push) |
| rf_wr_en_o | output | 1 | Register-file write strobe (pop) |
| rf_addr_o | output | 4 | Register index |
| rf_byte_o | output | 1 | Access targets the byte register |
| rf_rd_data_i | input | 16 | Register-file read data, same cycle |
| rf_wr_data_o | output | 16 | Register-file write data |
| mem_en_o | output | 1 | Stack memory access strobe |
| mem_we_o | output | 1 | Stack memory write (push) |
| mem_addr_o | output | 16 | Stack memory byte address |
| mem_wdata_o | output | 16 | Stack memory write data |
| mem_rdata_i | input | 16 | Stack memory read data, same cycle |

## Verification
The hardest case to reach from the ports is a second start that arrives in the middle of a transfer, with a different direction, mask and pointer. Any leak of the new request would show up as corrupted slots or a wrong final pointer. The bench drives such a request on the second busy cycle of a multi-register transfer, then checks the results and the cycle after done. Stack wrap is reached directly by pushing from a pointer near zero. Random transfers that alternate push and pop across both banks and both widths check ordering through the slot and register contents.

// File: rtl/regstk_pkg.sv
package regstk_pkg;
  // Per-transfer configuration captured at start
  typedef struct packed {
    logic pop;
    logic byte_mode;
    logic upper;
  } op_cfg_t;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/regstk_pick.sv
// Selects the next mask bit to service: lowest set bit, or highest when
// high_first is set. Bit order is mirrored so one priority chain serves both.
module regstk_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  input  logic          high_first,
  output logic [IW-1:0] idx,
  output logic          any
);
  logic [N-1:0]  ord;
  logic [IW-1:0] pos;

  for (genvar g = 0; g < N; g++) begin : g_mirror
    assign ord[g] = high_first ? req[N-1-g] : req[g];
  end

  always_comb begin
    pos = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (ord[k]) pos = IW'(k);
    end
  end

  assign idx = high_first ? (IW'(N - 1) - pos) : pos;
  assign any = |req;
endmodule

// File: rtl/regstk_dp.sv
// Address and data path for one register transfer per cycle.
module regstk_dp
  import regstk_pkg::*;
#(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IW     = 3
) (
  input  logic              active,
  input  op_cfg_t           cfg,
  input  logic [IW-1:0]     idx,
  input  logic [SP_W-1:0]   sp,
  input  logic [DATA_W-1:0] rf_rd_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [SP_W-1:0]   sp_next,
  output logic              rf_rd_en,
  output logic              rf_wr_en,
  output logic [IW:0]       rf_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [SP_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int unsigned        SLOT_BYTES = DATA_W / BYTE_W;
  localparam logic [SP_W-1:0]    STEP       = SP_W'(SLOT_BYTES);
  localparam int unsigned        PAD_W      = DATA_W - BYTE_W;

  logic [SP_W-1:0] sp_dec, sp_inc;

  assign sp_dec = sp - STEP;
  assign sp_inc = sp + STEP;

  assign sp_next  = cfg.pop ? sp_inc : sp_dec;
  assign mem_addr = cfg.pop ? sp : sp_dec;
  assign mem_en   = active;
  assign mem_we   = active & ~cfg.pop;
  assign rf_rd_en = active & ~cfg.pop;
  assign rf_wr_en = active & cfg.pop;
  assign rf_addr  = {cfg.upper, idx};

  assign mem_wdata  = cfg.byte_mode ? {{PAD_W{1'b0}}, rf_rd_data[BYTE_W-1:0]} : rf_rd_data;
  assign rf_wr_data = cfg.byte_mode ? {{PAD_W{1'b0}}, mem_rdata[BYTE_W-1:0]} : mem_rdata;
endmodule

// File: rtl/regstk_seq.sv
module regstk_seq
  import regstk_pkg::*;
#(
  parameter int unsigned MASK_W = 8,
  parameter int unsigned SP_W   = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IW    = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pop_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              upper_i,
  input  logic              byte_i,
  input  logic [SP_W-1:0]   sp_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [SP_W-1:0]   sp_o,
  output logic              rf_rd_en_o,
  output logic              rf_wr_en_o,
  output logic [IW:0]       rf_addr_o,
  output logic              rf_byte_o,
  input  logic [DATA_W-1:0] rf_rd_data_i,
  output logic [DATA_W-1:0] rf_wr_data_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [SP_W-1:0]   mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  op_cfg_t           cfg_q;
  logic              busy_q, done_q;
  logic [MASK_W-1:0] rem_q, rem_next;
  logic [SP_W-1:0]   sp_q, sp_next;
  logic [IW-1:0]     idx;
  logic              any;

  regstk_pick #(.N(MASK_W), .IW(IW)) pick_i (
    .req        (rem_q),
    .high_first (~cfg_q.pop),
    .idx        (idx),
    .any        (any)
  );

  regstk_dp #(.SP_W(SP_W), .DATA_W(DATA_W), .IW(IW)) dp_i (
    .active     (busy_q & any),
    .cfg        (cfg_q),
    .idx        (idx),
    .sp         (sp_q),
    .rf_rd_data (rf_rd_data_i),
    .mem_rdata  (mem_rdata_i),
    .sp_next    (sp_next),
    .rf_rd_en   (rf_rd_en_o),
    .rf_wr_en   (rf_wr_en_o),
    .rf_addr    (rf_addr_o),
    .rf_wr_data (rf_wr_data_o),
    .mem_en     (mem_en_o),
    .mem_we     (mem_we_o),
    .mem_addr   (mem_addr_o),
    .mem_wdata  (mem_wdata_o)
  );

  assign rem_next = rem_q & ~(MASK_W'(1) << idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      rem_q  <= '0;
      sp_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          cfg_q <= '{pop: pop_i, byte_mode: byte_i, upper: upper_i};
          sp_q  <= sp_i;
          rem_q <= mask_i;
          if (mask_i == '0) done_q <= 1'b1;
          else              busy_q <= 1'b1;
        end
      end else begin
        sp_q  <= sp_next;
        rem_q <= rem_next;
        if (rem_next == '0) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sp_o      = sp_q;
  assign rf_byte_o = cfg_q.byte_mode;
endmodule

// File: rtl/regstk_chk.sv
module regstk_chk #(
  parameter int unsigned SP_W   = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned AW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              rf_rd_en_o,
  input logic              rf_wr_en_o,
  input logic [AW-1:0]     rf_addr_o,
  input logic              rf_byte_o,
  input logic              mem_en_o,
  input logic              mem_we_o,
  input logic [SP_W-1:0]   mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o
);
  // R3: consecutive push stores step down by one slot
  assert_push_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && mem_we_o && $past(mem_en_o && mem_we_o && busy_o))
      |-> mem_addr_o == $past(mem_addr_o) - SP_W'(2));

  // R4: consecutive pop loads step up by one slot
  assert_pop_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o && !mem_we_o && $past(mem_en_o && !mem_we_o && busy_o))
      |-> mem_addr_o == $past(mem_addr_o) + SP_W'(2));

  // R5: a byte push leaves the upper half of the slot clear
  assert_byte_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_byte_o && rf_rd_en_o) |-> mem_wdata_o[DATA_W-1:8] == '0);

  // R6: accesses only while busy, done never overlaps busy
  assert_access_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_o || rf_rd_en_o || rf_wr_en_o) |-> busy_o);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  assert_one_port_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_rd_en_o, rf_wr_en_o}));

  // R9: direction and bank hold for the whole transfer, new starts notwithstanding
  assert_dir_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && start_i) |=> (!busy_o || $stable(mem_we_o)));
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> ($stable(rf_addr_o[AW-1]) && $stable(rf_byte_o)));
endmodule

bind regstk_seq regstk_chk #(.SP_W(SP_W), .DATA_W(DATA_W), .AW(IW + 1)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .rf_rd_en_o  (rf_rd_en_o),
  .rf_wr_en_o  (rf_wr_en_o),
  .rf_addr_o   (rf_addr_o),
  .rf_byte_o   (rf_byte_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o)
);

// File: tb/regstk_seq_tb.sv
`timescale 1ns/1ps
module regstk_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, pop_i = 1'b0, upper_i = 1'b0, byte_i = 1'b0;
  logic [7:0]  mask_i = '0;
  logic [15:0] sp_i = '0;
  logic        busy_o, done_o, rf_rd_en_o, rf_wr_en_o, rf_byte_o, mem_en_o, mem_we_o;
  logic [15:0] sp_o, rf_wr_data_o, mem_addr_o, mem_wdata_o;
  logic [15:0] rf_rd_data_i, mem_rdata_i;
  logic [3:0]  rf_addr_o;

  logic [15:0] wreg [16];
  logic [7:0]  breg [16];
  logic [15:0] smem [256];

  int errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  regstk_seq dut_i (.*);

  assign rf_rd_data_i = rf_byte_o ? {8'h00, breg[rf_addr_o]} : wreg[rf_addr_o];
  assign mem_rdata_i  = smem[mem_addr_o[8:1]];

  always @(posedge clk) begin
    if (mem_en_o && mem_we_o) smem[mem_addr_o[8:1]] <= mem_wdata_o;
    if (rf_wr_en_o) begin
      if (rf_byte_o) breg[rf_addr_o] <= rf_wr_data_o[7:0];
      else           wreg[rf_addr_o] <= rf_wr_data_o;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [7:0] m);
    int n = 0;
    for (int i = 0; i < 8; i++) n += m[i];
    return n;
  endfunction

  function automatic logic [15:0] exp_sp(input logic [15:0] sp, input logic [7:0] m, input bit pop);
    return pop ? sp + 16'(2 * popc(m)) : sp - 16'(2 * popc(m));
  endfunction

  logic [15:0] exp_reg [8];

  // Runs one transfer; inject drives a conflicting start on the second busy cycle
  task automatic run_op(input bit pop, input logic [7:0] m, input bit up, input bit byt,
                        input logic [15:0] sp, input bit inject);
    int cyc = 0, nb = 0;
    logic [15:0] s = sp;
    if (pop) begin
      for (int i = 0; i < 8; i++) if (m[i]) begin
        exp_reg[i] = byt ? {8'h00, smem[s[8:1]][7:0]} : smem[s[8:1]];
        s = s + 16'd2;
      end
    end
    @(negedge clk);
    pop_i = pop; mask_i = m; upper_i = up; byte_i = byt; sp_i = sp; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o && cyc < 40) begin
      if (busy_o) nb++;
      if (inject && cyc == 1) begin
        start_i = 1'b1; pop_i = ~pop; mask_i = 8'hFF; sp_i = 16'h1234;
      end else start_i = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
    chk(done_o, "R6 done pulse", done_o, 1);
    chk(nb == popc(m), "R6 busy cycles", nb, popc(m));
    chk(!busy_o, "R6 idle at done", busy_o, 0);
    chk(sp_o == exp_sp(sp, m, pop), "R8 final sp", sp_o, exp_sp(sp, m, pop));
    if (m == 8'h00) chk(cyc == 0, "R7 zero mask latency", cyc, 0);
    if (inject) begin
      @(negedge clk);
      chk(!done_o && !busy_o, "R9 start ignored while busy", {done_o, busy_o}, 0);
    end
    // data checks
    s = sp;
    if (!pop) begin
      for (int i = 7; i >= 0; i--) if (m[i]) begin
        logic [15:0] e;
        s = s - 16'd2;
        e = byt ? {8'h00, breg[{up, 3'(i)}]} : wreg[{up, 3'(i)}];
        chk(smem[s[8:1]] == e, byt ? "R3 R5 R2 push slot" : "R3 R2 push slot", smem[s[8:1]], e);
      end
    end else begin
      for (int i = 0; i < 8; i++) if (m[i]) begin
        logic [15:0] a = byt ? {8'h00, breg[{up, 3'(i)}]} : wreg[{up, 3'(i)}];
        chk(a == exp_reg[i], byt ? "R4 R5 R2 pop reg" : "R4 R2 pop reg", a, exp_reg[i]);
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < 16; i++) begin
      wreg[i] = 16'($urandom); breg[i] = 8'($urandom);
    end
    for (int i = 0; i < 256; i++) smem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_en_o && !rf_rd_en_o && !rf_wr_en_o, "R1 reset outputs",
        {busy_o, done_o, mem_en_o, rf_rd_en_o, rf_wr_en_o}, 0);
    rst_n = 1'b1;
    // R7 empty mask
    run_op(1'b0, 8'h00, 1'b0, 1'b0, 16'h0180, 1'b0);
    run_op(1'b1, 8'h00, 1'b1, 1'b1, 16'h0140, 1'b0);
    // full mask push then pop round trip, word, lower bank
    run_op(1'b0, 8'hFF, 1'b0, 1'b0, 16'h0100, 1'b0);
    for (int i = 0; i < 8; i++) wreg[i] = 16'h0;
    run_op(1'b1, 8'hFF, 1'b0, 1'b0, 16'h00F0, 1'b0);
    // single bits at both ends, upper bank, byte
    run_op(1'b0, 8'h80, 1'b1, 1'b1, 16'h0120, 1'b0);
    run_op(1'b1, 8'h01, 1'b1, 1'b1, 16'h011E, 1'b0);
    // R10 wrap below zero and back
    run_op(1'b0, 8'h23, 1'b1, 1'b0, 16'h0002, 1'b0);
    run_op(1'b1, 8'h23, 1'b0, 1'b0, 16'hFFFC, 1'b0);
    chk(sp_o == 16'h0002, "R10 wrap round trip", sp_o, 16'h0002);
    // R9 conflicting start mid-transfer, push and pop
    run_op(1'b0, 8'h5A, 1'b0, 1'b1, 16'h01C0, 1'b1);
    run_op(1'b1, 8'hE1, 1'b1, 1'b0, 16'h0060, 1'b1);
    // random mix
    for (int t = 0; t < 60; t++) begin
      run_op(1'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
             16'($urandom), (t % 7) == 3);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule